// File: doc/BRIEF.md
# Sprite Overlay Unit

This block places one movable glyph over the on-screen display raster. Software stages a pattern select, a screen position, a glyph colour and a trim colour through a small write port. The staged values move to the live set only on a frame-start pulse, so a frame never shows half of an old position and half of a new one. For each raster dot the block tests whether the dot falls inside the 24-dot by 32-line sprite window. It then issues a font address for the matching glyph row, and one cycle later reports whether the dot is a glyph dot or a trim dot, with its colour. A downstream composer gives this result priority over every character-layer pixel.

The pattern select picks one of eight font codes, 0x1F8 to 0x1FF. Positions are held in 2-dot units, so the top-left corner can sit on any even dot and even line of the screen. The glyph and trim colours are separate 3-bit palette indices.

A two-state machine tracks visibility. `ST_OFF` means no sprite is shown. `ST_LIVE` means the live registers describe a visible sprite. The transition OFF->LIVE happens on a frame-start pulse when the staged enable is 1. The transition LIVE->OFF happens on a frame-start pulse when the staged enable is 0. All other cycles hold the state.

Top module: `sprite_overlay`

## Requirements
- R1: After reset, `spr_hit`, `spr_is_trim`, `spr_color` and `font_addr` are 0, and no dot produces a hit until a frame-start pulse makes the sprite live.
- R2: A write with `wr_addr`=0 stages the control word: bit 0 enable, bits 3:1 pattern select, bits 6:4 glyph colour, bits 9:7 trim colour. `wr_addr`=1 stages the X position and `wr_addr`=2 stages the Y position, each in bits 8:0 and counted in 2-dot units.
- R3: Staged values have no effect until the clock edge on which `frame_start` is high. Until then, hits, colours and addresses follow the previous live set.
- R4: A dot is inside the window when 2*X <= `dot_x` < 2*X+24 and 2*Y <= `line_y` < 2*Y+32. Windows that start at dot 0 or line 0 are included.
- R5: For an inside dot, `font_addr` is {code, row}. The code is 0x1F8 plus the select, in bits 13:5. The row is `line_y`-2*Y, in bits 4:0.
- R6: If the glyph row bit for column c (bit 23-c, where c = `dot_x`-2*X) is set, the output is `spr_hit`=1 and `spr_is_trim`=0, with `spr_color` set to the glyph colour.
- R7: If the glyph bit is clear and the trim row bit for the same column is set, the output is `spr_hit`=1 and `spr_is_trim`=1, with `spr_color` set to the trim colour.
- R8: If the dot is outside the window, or both bits are clear, the output is `spr_hit`=0 and `spr_is_trim`=0, with `spr_color`=0.
- R9: `font_addr` changes on the first clock edge after a dot is presented. The hit and colour results appear on the second clock edge.
- R10: While the sprite is not live, no dot gives a hit.
- R11: A dot presented with `pix_valid` low gives no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Staged register select |
| wr_data | input | 16 | Write data |
| frame_start | input | 1 | One-cycle pulse at frame start; moves the staged set to the live set |
| pix_valid | input | 1 | Current dot is in the active raster |
| dot_x | input | 10 | Current dot counter |
| line_y | input | 10 | Current line counter |
| glyph_row | input | 24 | Glyph row read at `font_addr` |
| trim_row | input | 24 | Trim row read at `font_addr` |
| font_addr | output | 14 | Sprite font row address |
| spr_hit | output | 1 | Sprite dot overrides lower layers |
| spr_is_trim | output | 1 | The hit is a trim dot |
| spr_color | output | 3 | Palette index of the hit |

## Verification
A wrong visibility state shows up on the very next frame. A sprite that should be live gives no hits, or a disabled one keeps producing them. Live registers that update without a frame pulse show up within two cycles of the next probed dot, as a shifted window edge, a wrong code in `font_addr` or a swapped colour. Column or row misalignment shows up only at the window edges and on the alternating glyph and trim pattern. For that reason the first and last columns and rows are probed on both sides.

// File: rtl/sprite_pkg.sv
package sprite_pkg;

    localparam int SEL_W  = 3;
    localparam int COL_W  = 3;
    localparam int CODE_W = 9;
    localparam logic [CODE_W-1:0] SPRITE_BASE = 9'h1F8;

    typedef enum logic [0:0] {
        ST_OFF  = 1'b0,
        ST_LIVE = 1'b1
    } spr_state_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [COL_W-1:0] gcol;
        logic [COL_W-1:0] tcol;
    } spr_cfg_t;

endpackage

// File: rtl/sprite_regs.sv
module sprite_regs
    import sprite_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int XPOS_W = 9,
    parameter int YPOS_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_start,
    output logic              sprite_on,
    output spr_cfg_t          act_cfg,
    output logic [XPOS_W-1:0] act_x,
    output logic [YPOS_W-1:0] act_y
);

    localparam int EN_BIT   = 0;
    localparam int SEL_LSB  = 1;
    localparam int GCOL_LSB = SEL_LSB + SEL_W;
    localparam int TCOL_LSB = GCOL_LSB + COL_W;

    logic              stg_en;
    spr_cfg_t          stg_cfg;
    logic [XPOS_W-1:0] stg_x;
    logic [YPOS_W-1:0] stg_y;

    spr_state_e state_q, state_d;

    // staging registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_en  <= 1'b0;
            stg_cfg <= '0;
            stg_x   <= '0;
            stg_y   <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                2'd0: begin
                    stg_en       <= wr_data[EN_BIT];
                    stg_cfg.sel  <= wr_data[SEL_LSB  +: SEL_W];
                    stg_cfg.gcol <= wr_data[GCOL_LSB +: COL_W];
                    stg_cfg.tcol <= wr_data[TCOL_LSB +: COL_W];
                end
                2'd1: stg_x <= wr_data[XPOS_W-1:0];
                2'd2: stg_y <= wr_data[YPOS_W-1:0];
                default: ;
            endcase
        end
    end

    // live registers, loaded only at frame start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_cfg <= '0;
            act_x   <= '0;
            act_y   <= '0;
        end else if (frame_start) begin
            act_cfg <= stg_cfg;
            act_x   <= stg_x;
            act_y   <= stg_y;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (frame_start && stg_en)  state_d = ST_LIVE;
            ST_LIVE: if (frame_start && !stg_en) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_LIVE: sprite_on = 1'b1;
            default: sprite_on = 1'b0;
        endcase
    end

    // R3
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(act_x) && $stable(act_y) && $stable(act_cfg)));

    // R10
    go_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !stg_en) |=> !sprite_on);

endmodule

// File: rtl/sprite_window.sv
module sprite_window
    import sprite_pkg::*;
#(
    parameter int DOT_W   = 10,
    parameter int LINE_W  = 10,
    parameter int XPOS_W  = 9,
    parameter int YPOS_W  = 9,
    parameter int GLYPH_W = 24,
    parameter int GLYPH_H = 32,
    parameter int ROW_W   = $clog2(GLYPH_H),
    parameter int CIDX_W  = $clog2(GLYPH_W),
    parameter int ADDR_W  = CODE_W + ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic [DOT_W-1:0]  dot_x,
    input  logic [LINE_W-1:0] line_y,
    input  logic              sprite_on,
    input  logic [XPOS_W-1:0] act_x,
    input  logic [YPOS_W-1:0] act_y,
    input  logic [SEL_W-1:0]  sel,
    output logic [ADDR_W-1:0] font_addr,
    output logic              win_q,
    output logic [CIDX_W-1:0] col_q
);

    logic [DOT_W:0]  dx;
    logic [LINE_W:0] dy;
    logic            in_x, in_y, in_win;
    logic [CODE_W-1:0] code;

    always_comb begin
        dx     = {1'b0, dot_x}  - {1'b0, act_x, 1'b0};
        dy     = {1'b0, line_y} - {1'b0, act_y, 1'b0};
        in_x   = !dx[DOT_W]  && (dx[DOT_W-1:0]  < DOT_W'(GLYPH_W));
        in_y   = !dy[LINE_W] && (dy[LINE_W-1:0] < LINE_W'(GLYPH_H));
        in_win = pix_valid && sprite_on && in_x && in_y;
        code   = SPRITE_BASE | CODE_W'(sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q     <= 1'b0;
            col_q     <= '0;
            font_addr <= '0;
        end else begin
            win_q <= in_win;
            if (in_win) begin
                col_q     <= dx[CIDX_W-1:0];
                font_addr <= {code, dy[ROW_W-1:0]};
            end
        end
    end

    // R10
    off_no_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sprite_on |=> !win_q);

    // R11
    blank_no_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !win_q);

endmodule

// File: rtl/sprite_pixel.sv
module sprite_pixel
    import sprite_pkg::*;
#(
    parameter int GLYPH_W = 24,
    parameter int CIDX_W  = $clog2(GLYPH_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_q,
    input  logic [CIDX_W-1:0]  col_q,
    input  logic [GLYPH_W-1:0] glyph_row,
    input  logic [GLYPH_W-1:0] trim_row,
    input  logic [COL_W-1:0]   gcol,
    input  logic [COL_W-1:0]   tcol,
    output logic               spr_hit,
    output logic               spr_is_trim,
    output logic [COL_W-1:0]   spr_color
);

    localparam logic [GLYPH_W-1:0] LEFT_BIT = {1'b1, {(GLYPH_W-1){1'b0}}};

    logic [GLYPH_W-1:0] mask;
    logic               gbit, tbit;

    always_comb begin
        mask = LEFT_BIT >> col_q;
        gbit = win_q && |(glyph_row & mask);
        tbit = win_q && !gbit && |(trim_row & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spr_hit     <= 1'b0;
            spr_is_trim <= 1'b0;
            spr_color   <= '0;
        end else begin
            spr_hit     <= gbit || tbit;
            spr_is_trim <= tbit;
            spr_color   <= gbit ? gcol : (tbit ? tcol : '0);
        end
    end

    // R7
    trim_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spr_is_trim |-> spr_hit);

    // R8
    idle_color_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spr_hit |-> (spr_color == '0));

    // R9
    no_window_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_q |=> !spr_hit);

endmodule

// File: rtl/sprite_overlay.sv
module sprite_overlay
    import sprite_pkg::*;
#(
    parameter int DOT_W   = 10,
    parameter int LINE_W  = 10,
    parameter int DATA_W  = 16,
    parameter int GLYPH_W = 24,
    parameter int GLYPH_H = 32,
    parameter int ROW_W   = $clog2(GLYPH_H),
    parameter int ADDR_W  = CODE_W + ROW_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               frame_start,
    input  logic               pix_valid,
    input  logic [DOT_W-1:0]   dot_x,
    input  logic [LINE_W-1:0]  line_y,
    input  logic [GLYPH_W-1:0] glyph_row,
    input  logic [GLYPH_W-1:0] trim_row,
    output logic [ADDR_W-1:0]  font_addr,
    output logic               spr_hit,
    output logic               spr_is_trim,
    output logic [COL_W-1:0]   spr_color
);

    localparam int XPOS_W = DOT_W - 1;
    localparam int YPOS_W = LINE_W - 1;
    localparam int CIDX_W = $clog2(GLYPH_W);

    logic              sprite_on;
    spr_cfg_t          act_cfg;
    logic [XPOS_W-1:0] act_x;
    logic [YPOS_W-1:0] act_y;
    logic              win_q;
    logic [CIDX_W-1:0] col_q;

    sprite_regs #(
        .DATA_W(DATA_W), .XPOS_W(XPOS_W), .YPOS_W(YPOS_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_start(frame_start),
        .sprite_on(sprite_on), .act_cfg(act_cfg),
        .act_x(act_x), .act_y(act_y)
    );

    sprite_window #(
        .DOT_W(DOT_W), .LINE_W(LINE_W), .XPOS_W(XPOS_W), .YPOS_W(YPOS_W),
        .GLYPH_W(GLYPH_W), .GLYPH_H(GLYPH_H), .ROW_W(ROW_W),
        .CIDX_W(CIDX_W), .ADDR_W(ADDR_W)
    ) u_window (
        .clk(clk), .rst_n(rst_n),
        .pix_valid(pix_valid), .dot_x(dot_x), .line_y(line_y),
        .sprite_on(sprite_on), .act_x(act_x), .act_y(act_y),
        .sel(act_cfg.sel),
        .font_addr(font_addr), .win_q(win_q), .col_q(col_q)
    );

    sprite_pixel #(
        .GLYPH_W(GLYPH_W), .CIDX_W(CIDX_W)
    ) u_pixel (
        .clk(clk), .rst_n(rst_n),
        .win_q(win_q), .col_q(col_q),
        .glyph_row(glyph_row), .trim_row(trim_row),
        .gcol(act_cfg.gcol), .tcol(act_cfg.tcol),
        .spr_hit(spr_hit), .spr_is_trim(spr_is_trim), .spr_color(spr_color)
    );

endmodule

// File: tb/sprite_overlay_bench.sv
`timescale 1ns/1ps
module sprite_overlay_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        frame_start = 1'b0;
    logic        pix_valid = 1'b0;
    logic [9:0]  dot_x = '0;
    logic [9:0]  line_y = '0;
    logic [23:0] glyph_row, trim_row;
    logic [13:0] font_addr;
    logic        spr_hit, spr_is_trim;
    logic [2:0]  spr_color;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sprite_overlay u_sprite_overlay (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_start(frame_start), .pix_valid(pix_valid),
        .dot_x(dot_x), .line_y(line_y), .glyph_row(glyph_row),
        .trim_row(trim_row), .font_addr(font_addr), .spr_hit(spr_hit),
        .spr_is_trim(spr_is_trim), .spr_color(spr_color)
    );

    // font model: glyph where (col+row+sel)%3==0, trim where ==1
    always_comb begin
        glyph_row = '0;
        trim_row  = '0;
        for (int c = 0; c < 24; c++) begin
            int s;
            s = c + int'(font_addr[4:0]) + int'(font_addr[7:5]);
            if (s % 3 == 0) glyph_row[23-c] = 1'b1;
            if (s % 3 == 1) trim_row[23-c]  = 1'b1;
        end
    end

    typedef struct packed {
        logic [9:0] dot;
        logic [9:0] line;
        logic       win;
        logic       hit;
        logic       trm;
        logic [2:0] col;
    } vec_t;

    // sprite at x=100, y=40, select 5, glyph colour 6, trim colour 3
    localparam vec_t VECS [11] = '{
        '{10'd100, 10'd40, 1'b1, 1'b0, 1'b0, 3'd0},
        '{10'd101, 10'd40, 1'b1, 1'b1, 1'b0, 3'd6},
        '{10'd102, 10'd40, 1'b1, 1'b1, 1'b1, 3'd3},
        '{10'd123, 10'd70, 1'b1, 1'b1, 1'b1, 3'd3},
        '{10'd124, 10'd40, 1'b0, 1'b0, 1'b0, 3'd0},
        '{10'd99,  10'd40, 1'b0, 1'b0, 1'b0, 3'd0},
        '{10'd110, 10'd72, 1'b0, 1'b0, 1'b0, 3'd0},
        '{10'd110, 10'd39, 1'b0, 1'b0, 1'b0, 3'd0},
        '{10'd110, 10'd55, 1'b1, 1'b1, 1'b0, 3'd6},
        '{10'd122, 10'd71, 1'b1, 1'b1, 1'b1, 3'd3},
        '{10'd100, 10'd71, 1'b1, 1'b1, 1'b0, 3'd6}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic probe(input logic [9:0] dx, input logic [9:0] ly, input logic v,
                         output logic [13:0] a, output logic h, output logic t,
                         output logic [2:0] c);
        @(negedge clk);
        dot_x = dx; line_y = ly; pix_valid = v;
        @(negedge clk);
        a = font_addr;
        pix_valid = 1'b0;
        @(negedge clk);
        h = spr_hit; t = spr_is_trim; c = spr_color;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [13:0] a;
        logic h, t;
        logic [2:0] c;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 hit", spr_hit, 0);
        chk("R1 trim", spr_is_trim, 0);
        chk("R1 color", spr_color, 0);
        chk("R1 addr", font_addr, 0);

        // R2 staging: en=1 sel=5 gcol=6 tcol=3, X=50, Y=20
        wr(2'd0, 16'h01EB);
        wr(2'd1, 16'd50);
        wr(2'd2, 16'd20);
        // R3 not live before frame start
        probe(10'd101, 10'd40, 1'b1, a, h, t, c);
        chk("R3 no hit before frame", h, 0);
        frame();

        for (int i = 0; i < 11; i++) begin
            probe(VECS[i].dot, VECS[i].line, 1'b1, a, h, t, c);
            if (VECS[i].win)   // R5 R9
                chk("R5 addr", a, {9'h1FD, 5'(VECS[i].line - 10'd40)});
            chk("R4 R6 R8 hit", h, VECS[i].hit);
            chk("R7 trim", t, VECS[i].trm);
            chk("R6 R7 color", c, VECS[i].col);
        end

        // R3 new X staged, old window still live
        wr(2'd1, 16'd0);
        probe(10'd101, 10'd40, 1'b1, a, h, t, c);
        chk("R3 old position hit", h, 1);
        chk("R3 old position color", c, 6);
        frame();
        // R4 window at dot 0
        probe(10'd1, 10'd40, 1'b1, a, h, t, c);
        chk("R4 left edge hit", h, 1);
        probe(10'd101, 10'd40, 1'b1, a, h, t, c);
        chk("R4 old window gone", h, 0);

        // R5 select 0 gives code 0x1F8
        wr(2'd0, 16'h01E1);
        frame();
        probe(10'd0, 10'd40, 1'b1, a, h, t, c);
        chk("R5 code 1F8", a, {9'h1F8, 5'd0});
        chk("R6 sel0 glyph", h, 1);

        // R11 blank dot
        probe(10'd0, 10'd40, 1'b0, a, h, t, c);
        chk("R11 no hit when invalid", h, 0);

        // R10 disable
        wr(2'd0, 16'h01E0);
        frame();
        probe(10'd0, 10'd40, 1'b1, a, h, t, c);
        chk("R10 no hit when off", h, 0);
        chk("R10 color zero", c, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule